// File: doc/BRIEF.md
# Controller-Side Address Translation Cache

This block sits inside a memory controller. It turns a stream of pseudo-virtual addresses into real physical addresses. Translations for 4 KB pages are cached in a 256-entry, 4-way set-associative table. When a page is not cached, the block reads its entry from a dense, flat page table in physical memory. That table starts at an address given on a base-register input and is indexed directly by the pseudo-virtual page number.

Requests enter with a valid/ready handshake and travel through a fixed four-stage pipeline. The lookup happens in the last stage before the output register. When the lookup misses, the whole pipeline freezes, the entry is fetched over a simple read port, and it is installed in the way that the set's round-robin pointer selects. The stalled request then completes, and the requests behind it follow in their original order. A single-cycle invalidate input drops every cached translation.

Top module: `pv_xlate_tlb`

## Requirements
- R1: After synchronous active-low reset, `out_valid` and `mem_rd_valid` are low, `in_ready` is high and no translation is cached, so the first access to any page issues a table read.
- R2: A request accepted in cycle k that hits appears on `out_valid`/`out_pa` in cycle k+4. Back-to-back hits stream out one per cycle in order.
- R3: While the request in the lookup stage misses, `in_ready` is low, nothing is accepted, the pipeline holds, and `out_valid` is low in the following cycle.
- R4: A miss raises `mem_rd_valid` one cycle after detection, with `mem_rd_addr` = page-table base + page number × 4. The address stays stable until `mem_rd_ready`. Exactly one read is made per miss.
- R5: The returned entry's bits [19:0] are the physical page number, and the upper bits are ignored. `out_pa` = {page number, va[11:0]}. A response that arrives while no read is outstanding is ignored.
- R6: The set index is page number bits [5:0] and the tag is the remaining bits. Up to four distinct pages that share a set stay cached together and never match in more than one way.
- R7: A refill writes the way named by its set's round-robin pointer, which then advances 0,1,2,3,0. The fifth page in a set therefore evicts the first one that was installed.
- R8: A one-cycle `inv_all` pulse clears every cached translation, so later accesses to previously cached pages miss again. A refill that lands in the same cycle is kept.
- R9: Every accepted request produces exactly one output, and no request is lost or duplicated under input bubbles, slow memory handshakes and stray responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inv_all | input | 1 | Drop all cached translations |
| ptbase | input | 32 | Physical base address of the flat page table |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_va | input | 32 | Pseudo-virtual address |
| out_valid | output | 1 | Translated address valid |
| out_pa | output | 32 | Translated physical address |
| mem_rd_valid | output | 1 | Page-table read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 32 | Byte address of the page-table entry |
| mem_rsp_valid | input | 1 | Page-table entry returned |
| mem_rsp_data | input | 32 | Page-table entry |

## Verification
The bench fills one set with five pages and then revisits them in a chosen order. A design with the wrong victim choice, or with duplicate ways, shows a different number of table reads. It fires invalidates in the middle of traffic and sends responses when no read is outstanding. A design that keeps stale entries, or accepts a stray entry, produces a wrong address. Slow read handshakes and input bubbles target stall handling: a pipeline that leaks a request during a stall drops or repeats outputs, or shifts their timing off the four-cycle latency.

// File: rtl/pvt_pkg.sv
`timescale 1ns/1ps
// Shared types for the controller-side translation cache.
package pvt_pkg;
    // Refill sequencer states: idle, read request pending, entry awaited.
    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_ASK  = 2'd1,
        FILL_WAIT = 2'd2
    } fill_state_e;
endpackage

// File: rtl/pvt_ways.sv
`timescale 1ns/1ps
// Set-associative translation store.
// Does: holds tag, page number and valid per way; combinational lookup of one
// set; installs a refill into the set's round-robin victim; clears all valid
// bits on invalidate (a refill in the same cycle still lands).
// Assumes: WAYS <= 2**WAY_W; the data arrays need no reset.
module pvt_ways #(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int SET_W = 6,
    parameter int TAG_W = 14,
    parameter int PPN_W = 20,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [WAYS-1:0]  lk_hitvec,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn
);
    logic [WAYS-1:0]  vld  [SETS];
    logic [TAG_W-1:0] tags [SETS][WAYS];
    logic [PPN_W-1:0] ppns [SETS][WAYS];
    logic [WAY_W-1:0] rr   [SETS];

    // Per-way tag comparison against the addressed set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_hitvec[w] = vld[lk_set][w] && (tags[lk_set][w] == lk_tag);
    end

    // Select the page number of the matching way.
    always_comb begin
        lk_ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_hitvec[w]) lk_ppn = lk_ppn | ppns[lk_set][w];
        end
    end

    // Valid bits and victim pointers: reset, invalidate, refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s] <= '0;
                rr[s]  <= '0;
            end
        end else begin
            if (inv_all) begin
                for (int s = 0; s < SETS; s++) vld[s] <= '0;
            end
            if (wr_en) begin
                vld[wr_set][rr[wr_set]] <= 1'b1;
                rr[wr_set] <= (rr[wr_set] == WAY_W'(WAYS - 1)) ? '0 : rr[wr_set] + 1'b1;
            end
        end
    end

    // Tag and page-number storage for the victim way.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_set][rr[wr_set]] <= wr_tag;
            ppns[wr_set][rr[wr_set]] <= wr_ppn;
        end
    end
endmodule

// File: rtl/pvt_refill.sv
`timescale 1ns/1ps
// Page-table refill sequencer.
// Does: on a miss, computes base + page number * entry size, holds a read
// request until accepted, then installs the page number from the returned entry.
// Assumes: PTE_BYTES is a power of two; the miss input stays high until the
// fill lands; responses outside the wait state are ignored.
module pvt_refill
    import pvt_pkg::*;
#(
    parameter int PA_W      = 32,
    parameter int VPN_W     = 20,
    parameter int PPN_W     = 20,
    parameter int PTE_W     = 32,
    parameter int PTE_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic [PA_W-1:0]  ptbase,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             fill_en,
    output logic [PPN_W-1:0] fill_ppn
);
    localparam int ENT_SH = $clog2(PTE_BYTES);

    fill_state_e     st;
    logic [PA_W-1:0] addr_q;
    logic            unused_pte_hi;

    assign unused_pte_hi = ^mem_rsp_data[PTE_W-1:PPN_W];
    assign mem_rd_valid  = (st == FILL_ASK);
    assign mem_rd_addr   = addr_q;
    assign fill_en       = (st == FILL_WAIT) && mem_rsp_valid;
    assign fill_ppn      = mem_rsp_data[PPN_W-1:0];

    // Sequence one table read per miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= FILL_IDLE;
        end else begin
            case (st)
                FILL_IDLE: if (miss)          st <= FILL_ASK;
                FILL_ASK:  if (mem_rd_ready)  st <= FILL_WAIT;
                FILL_WAIT: if (mem_rsp_valid) st <= FILL_IDLE;
                default:                      st <= FILL_IDLE;
            endcase
        end
    end

    // Capture the entry address when the miss is first seen.
    always_ff @(posedge clk) begin
        if (st == FILL_IDLE && miss) addr_q <= ptbase + (PA_W'(miss_vpn) << ENT_SH);
    end
endmodule

// File: rtl/pv_xlate_tlb.sv
`timescale 1ns/1ps
// Pipelined controller-side translation cache (top).
// Does: accepts pseudo-virtual addresses, delays them two stages, looks them
// up in the third, registers the physical address in the fourth; a miss in
// the lookup stage freezes every stage until the refill is installed.
// Assumes: ptbase is stable while a miss is pending; pages of 2**PG_BITS bytes.
module pv_xlate_tlb #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PG_BITS   = 12,
    parameter int ENTRIES   = 256,
    parameter int WAYS      = 4,
    parameter int PTE_W     = 32,
    parameter int PTE_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inv_all,
    input  logic [PA_W-1:0] ptbase,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [VA_W-1:0] in_va,
    output logic            out_valid,
    output logic [PA_W-1:0] out_pa,
    output logic            mem_rd_valid,
    input  logic            mem_rd_ready,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    localparam int VPN_W = VA_W - PG_BITS;
    localparam int PPN_W = PA_W - PG_BITS;
    localparam int SETS  = ENTRIES / WAYS;
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int DLY   = 3;

    logic [DLY-1:0]     st_v;
    logic [VPN_W-1:0]   st_vpn [DLY];
    logic [PG_BITS-1:0] st_off [DLY];

    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  lk_hitvec;
    logic [PPN_W-1:0] lk_ppn;
    logic             lk_hit;
    logic             stall;
    logic             fill_en;
    logic [PPN_W-1:0] fill_ppn;

    assign lk_set   = st_vpn[DLY-1][SET_W-1:0];
    assign lk_tag   = st_vpn[DLY-1][VPN_W-1:SET_W];
    assign lk_hit   = |lk_hitvec;
    assign stall    = st_v[DLY-1] && !lk_hit;
    assign in_ready = !stall;

    pvt_ways #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W),
        .TAG_W(TAG_W), .PPN_W(PPN_W), .WAY_W(WAY_W)
    ) u_ways (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .lk_set(lk_set), .lk_tag(lk_tag), .lk_hitvec(lk_hitvec), .lk_ppn(lk_ppn),
        .wr_en(fill_en), .wr_set(lk_set), .wr_tag(lk_tag), .wr_ppn(fill_ppn)
    );

    pvt_refill #(
        .PA_W(PA_W), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .PTE_W(PTE_W), .PTE_BYTES(PTE_BYTES)
    ) u_refill (
        .clk(clk), .rst_n(rst_n), .miss(stall), .miss_vpn(st_vpn[DLY-1]),
        .ptbase(ptbase), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .fill_en(fill_en), .fill_ppn(fill_ppn)
    );

    // Stage valid bits and output valid; frozen and bubbled on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v      <= '0;
            out_valid <= 1'b0;
        end else if (!stall) begin
            st_v      <= {st_v[DLY-2:0], in_valid};
            out_valid <= st_v[DLY-1];
        end else begin
            out_valid <= 1'b0;
        end
    end

    // Stage payloads and the registered physical address.
    always_ff @(posedge clk) begin
        if (!stall) begin
            for (int i = DLY - 1; i > 0; i--) begin
                st_vpn[i] <= st_vpn[i-1];
                st_off[i] <= st_off[i-1];
            end
            st_vpn[0] <= in_va[VA_W-1:PG_BITS];
            st_off[0] <= in_va[PG_BITS-1:0];
            out_pa    <= {lk_ppn, st_off[DLY-1]};
        end
    end
endmodule

// File: rtl/pvt_checks.sv
`timescale 1ns/1ps
// Protocol and structure checks for the translation cache, bound to the top.
module pvt_checks #(
    parameter int WAYS = 4,
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic            out_valid,
    input logic            mem_rd_valid,
    input logic            mem_rd_ready,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic [WAYS-1:0] hitvec
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !mem_rd_valid);

    assert_stall_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> !out_valid);

    assert_no_accept_in_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !in_ready);

    assert_read_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    assert_single_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hitvec));
endmodule

bind pv_xlate_tlb pvt_checks #(.WAYS(WAYS), .PA_W(PA_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .hitvec(lk_hitvec)
);

// File: tb/pv_xlate_tlb_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the design every cycle.
module pv_xlate_tlb_test;
    localparam logic [31:0] BASE = 32'h0040_0000;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_all = 1'b0;
    logic [31:0] ptbase = BASE;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_va = '0;
    logic        out_valid;
    logic [31:0] out_pa;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    pv_xlate_tlb uut (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .ptbase(ptbase),
        .in_valid(in_valid), .in_ready(in_ready), .in_va(in_va),
        .out_valid(out_valid), .out_pa(out_pa),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always #5 clk = ~clk;

    // Reference model state.
    bit          m_vld [64][4];
    int          m_tag [64][4];
    logic [19:0] m_ppn [64][4];
    int          m_rr  [64];
    int          p_v [3];
    int          p_vpn [3];
    int          p_off [3];
    bit          o_v;
    logic [31:0] o_pa;
    int          mst;
    logic [31:0] maddr;
    int          resp_cnt;
    logic [31:0] resp_addr;
    logic [31:0] pend [$];
    bit          slow, bubbles, stray_en, inv_req;
    int          cyc, checks, fails, rd_count, out_count, acc_count;

    function automatic logic [19:0] ppn_of(input int vpn);
        return 20'((vpn * 37 + 11) & 32'hFFFFF);
    endfunction

    function automatic logic [31:0] va(input int vpn, input int off);
        return {20'(vpn), 12'(off)};
    endfunction

    function automatic bit mlook(input int vpn, output logic [19:0] ppn);
        int s = vpn % 64;
        int t = vpn / 64;
        ppn = '0;
        for (int w = 0; w < 4; w++) begin
            if (m_vld[s][w] && m_tag[s][w] == t) begin
                ppn = m_ppn[s][w];
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // One clock of stimulus, comparison and model update.
    task automatic step();
        bit hc, stall, fill;
        logic [19:0] hp;
        int s, w;
        @(negedge clk);
        cyc++;
        in_valid = (pend.size() > 0) && !(bubbles && (cyc % 4 == 1));
        in_va    = (pend.size() > 0) ? pend[0] : 32'h0;
        inv_all  = inv_req;
        mem_rd_ready = !(slow && (cyc % 3 != 0));
        if (resp_cnt == 1) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = {12'hA5C, ppn_of(int'((resp_addr - BASE) >> 2))};
        end else if (stray_en && resp_cnt == 0 && mst != 2 && (cyc % 7 == 3)) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 32'hDEAD_BEEF;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        #1;
        hc    = p_v[2] != 0 && mlook(p_vpn[2], hp);
        stall = p_v[2] != 0 && !hc;
        chk(out_valid == o_v, "R2", "out_valid", 32'(out_valid), 32'(o_v));
        if (o_v) chk(out_pa == o_pa, "R2/R5", "out_pa", out_pa, o_pa);
        chk(in_ready == !stall, "R3", "in_ready", 32'(in_ready), 32'(!stall));
        chk(mem_rd_valid == (mst == 1), "R4", "mem_rd_valid", 32'(mem_rd_valid), 32'(mst == 1));
        if (mst == 1) chk(mem_rd_addr == maddr, "R4", "mem_rd_addr", mem_rd_addr, maddr);
        if (mem_rd_valid && mem_rd_ready) rd_count++;
        if (out_valid) out_count++;
        // model next state
        fill = (mst == 2) && mem_rsp_valid;
        if (resp_cnt > 0) resp_cnt--;
        if (mst == 1 && mem_rd_ready) begin
            resp_cnt  = LAT;
            resp_addr = maddr;
        end
        if (inv_all) begin
            for (int a = 0; a < 64; a++)
                for (int b = 0; b < 4; b++) m_vld[a][b] = 1'b0;
        end
        if (fill) begin
            s = p_vpn[2] % 64;
            w = m_rr[s];
            m_vld[s][w] = 1'b1;
            m_tag[s][w] = p_vpn[2] / 64;
            m_ppn[s][w] = mem_rsp_data[19:0];
            m_rr[s] = (w + 1) % 4;
        end
        if (mst == 0 && stall) begin
            maddr = BASE + 32'(p_vpn[2]) * 4;
            mst = 1;
        end else if (mst == 1 && mem_rd_ready) begin
            mst = 2;
        end else if (fill) begin
            mst = 0;
        end
        if (!stall) begin
            o_v  = p_v[2] != 0;
            o_pa = {hp, 12'(p_off[2])};
            p_v[2] = p_v[1]; p_vpn[2] = p_vpn[1]; p_off[2] = p_off[1];
            p_v[1] = p_v[0]; p_vpn[1] = p_vpn[0]; p_off[1] = p_off[0];
            p_v[0] = int'(in_valid); p_vpn[0] = int'(in_va[31:12]); p_off[0] = int'(in_va[11:0]);
            if (in_valid) begin
                void'(pend.pop_front());
                acc_count++;
            end
        end else begin
            o_v = 1'b0;
        end
        inv_req = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((pend.size() > 0 || p_v[0] != 0 || p_v[1] != 0 || p_v[2] != 0 ||
                mst != 0 || o_v || resp_cnt != 0) && guard < 5000) begin
            step();
            guard++;
        end
        step();
        step();
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #1500000;
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int r0, a0, k;
        for (int a = 0; a < 64; a++) begin
            m_rr[a] = 0;
            for (int b = 0; b < 4; b++) m_vld[a][b] = 1'b0;
        end
        for (int i = 0; i < 3; i++) p_v[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: quiet state after reset
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);
        chk(mem_rd_valid == 1'b0, "R1", "mem_rd_valid after reset", 32'(mem_rd_valid), 0);

        // R1: empty cache, four cold pages in different sets
        r0 = rd_count;
        pend.push_back(va(20'h00A01, 12'h010));
        pend.push_back(va(20'h12345, 12'h7FF));
        pend.push_back(va(20'h0BEEF, 12'h000));
        pend.push_back(va(20'h00777, 12'hFFF));
        drain();
        chk(rd_count - r0 == 4, "R1", "reads for cold pages", 32'(rd_count - r0), 4);

        // R2: back-to-back hits, no reads
        r0 = rd_count;
        for (int i = 0; i < 8; i++) begin
            case (i % 4)
                0: pend.push_back(va(20'h00A01, i * 17));
                1: pend.push_back(va(20'h12345, i * 17));
                2: pend.push_back(va(20'h0BEEF, i * 17));
                default: pend.push_back(va(20'h00777, i * 17));
            endcase
        end
        drain();
        chk(rd_count - r0 == 0, "R2", "reads during hit stream", 32'(rd_count - r0), 0);

        // R2, R5: exact hit latency and address composition
        a0 = acc_count;
        pend.push_back(va(20'h12345, 12'h0FC));
        do step(); while (acc_count == a0);
        k = cyc;
        do step(); while (!out_valid && cyc - k < 20);
        chk(cyc - k == 4, "R2", "hit latency", 32'(cyc - k), 4);
        chk(out_pa == {ppn_of(20'h12345), 12'h0FC}, "R5", "translated address",
            out_pa, {ppn_of(20'h12345), 12'h0FC});
        drain();

        // R6: five pages in set 5; first one evicted, the other four stay
        r0 = rd_count;
        for (int i = 0; i < 5; i++) pend.push_back(va(i * 64 + 5, i));
        drain();
        chk(rd_count - r0 == 5, "R6", "reads filling set", 32'(rd_count - r0), 5);
        r0 = rd_count;
        for (int i = 1; i < 5; i++) pend.push_back(va(i * 64 + 5, 12'h100 + i));
        drain();
        chk(rd_count - r0 == 0, "R6", "four resident pages hit", 32'(rd_count - r0), 0);

        // R7: round-robin victim order
        r0 = rd_count;
        pend.push_back(va(5, 12'h222));
        drain();
        chk(rd_count - r0 == 1, "R7", "evicted page refetched", 32'(rd_count - r0), 1);
        r0 = rd_count;
        for (int i = 2; i < 5; i++) pend.push_back(va(i * 64 + 5, 12'h333));
        drain();
        chk(rd_count - r0 == 0, "R7", "non-victims still hit", 32'(rd_count - r0), 0);
        r0 = rd_count;
        pend.push_back(va(64 + 5, 12'h444));
        drain();
        chk(rd_count - r0 == 1, "R7", "second victim refetched", 32'(rd_count - r0), 1);

        // R8: invalidate all
        inv_req = 1'b1;
        step();
        r0 = rd_count;
        pend.push_back(va(2 * 64 + 5, 12'h010));
        pend.push_back(va(20'h12345, 12'h020));
        pend.push_back(va(20'h00A01, 12'h030));
        drain();
        chk(rd_count - r0 == 3, "R8", "reads after invalidate", 32'(rd_count - r0), 3);

        // R9: mixed traffic, slow handshake, bubbles, stray responses, mid invalidate
        slow = 1'b1; bubbles = 1'b1; stray_en = 1'b1;
        for (int i = 0; i < 30; i++) pend.push_back(va(((i * 5) % 7) * 64 + 9 + (i % 3), i * 131));
        repeat (15) step();
        inv_req = 1'b1;
        for (int i = 30; i < 60; i++) pend.push_back(va(((i * 5) % 7) * 64 + 9 + (i % 3), i * 131));
        drain();
        chk(pend.size() == 0, "R9", "pending requests left", 32'(pend.size()), 0);
        chk(out_count == acc_count, "R9", "outputs vs accepted", 32'(out_count), 32'(acc_count));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule